// File: doc/BRIEF.md
# Complementary output idle-state controller

This block drives the pins of one complementary output channel (a main pin and its complementary pin) and one single-ended output pin. While the master output enable is high, the main pin follows a reference waveform, the complementary pin follows the inverse of that waveform, and a programmable dead-time is placed between every change of the pair. The single-ended pin follows its own reference waveform.

When the master output enable drops, each pin moves to an idle level held in a small configuration register. The complementary pair reaches its idle levels only after a dead-time. The single-ended pin reaches its idle level on the next cycle. A lock register, once it is made nonzero, write-protects the idle levels until the next reset. The lock register itself can be written only while it is still zero.

Reference waveforms come from a compare stage and the enable from a protection stage. Both stages sit outside this block.

Top module: `cmpl_idle_out`

## Requirements
- R1: A synchronous reset drives all three pins to 0, clears the idle levels to 0 and clears the lock level to 0.
- R2: While the enable is high, the single-ended pin equals the single-ended reference sampled one clock edge earlier.
- R3: While the enable is high, the pair's target is main = reference and complementary = inverted reference. When a clock edge sees a new target, both pins are 0 after that edge and for the next D-1 edges, where D is the dead-time count. The new levels appear after edge D, counting the triggering edge as edge 0.
- R4: On any cycle that follows an edge at which the enable was high, the main pin and the complementary pin are never both 1.
- R5: While the enable is low, the single-ended pin equals idle bit 2 one clock edge later.
- R6: When the enable falls, the pair's target becomes main = idle bit 0 and complementary = idle bit 1. This target passes through the same dead-time as in R3, and it does so even when the idle levels equal the levels the pins already have. A change of the idle bits while the enable is low also passes through the dead-time.
- R7: A dead-time count of 0 applies the new target on the first edge after the change, with no cycle at 0/0.
- R8: If the enable rises again while an idle dead-time countdown is running, the countdown is dropped. The enabled levels then appear after a fresh dead-time of D cycles from the edge that sees the enable high.
- R9: A configuration write while the lock level is 0 loads the idle bits from the write data: bit 0 sets the main pin's idle level, bit 1 the complementary pin's, and bit 2 the single-ended pin's.
- R10: While the lock level is nonzero, configuration writes leave the idle bits unchanged.
- R11: A lock write loads the lock level only while the lock level is 0. Once it is nonzero, lock writes are ignored until reset, and that includes writes of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ref1_i | input | 1 | Reference waveform for the complementary channel |
| ref2_i | input | 1 | Reference waveform for the single-ended channel |
| moe_i | input | 1 | Master output enable |
| dt_i | input | DT_W | Dead-time in clock cycles |
| cfg_we_i | input | 1 | Write strobe for the idle-level bits |
| cfg_wdata_i | input | 3 | Idle levels: bit 0 main, bit 1 complementary, bit 2 single-ended |
| lock_we_i | input | 1 | Write strobe for the lock level |
| lock_wdata_i | input | LOCK_W | Lock level write data |
| ch1_o | output | 1 | Main pin of the complementary channel |
| ch1n_o | output | 1 | Complementary pin |
| ch2_o | output | 1 | Single-ended pin |

## Verification
Some properties are checked on every cycle: the single-ended pin's one-cycle following of its reference or idle bit, the ban on both pair pins being high after an enabled edge, the freezing of the idle bits and the lock level once locked, and the reset values. The exact length of each 0/0 dead-time window, and the restart of the countdown when the enable returns mid-countdown, are shown only by the bench's scenarios. Those scenarios sweep the dead-time over several values and the idle code over all eight patterns, and count the cycles at the pins. The bench also shows the lock's effect at the pins: it observes that writes made after locking leave the idle levels unchanged.

// File: rtl/cmpl_idle_out_pkg.sv
package cmpl_idle_out_pkg;
  // Idle-level bits: [2] single-ended, [1] complementary, [0] main
  typedef struct packed {
    logic se;
    logic neg;
    logic pos;
  } idle_t;
endpackage

// File: rtl/cmpl_idle_regs.sv
module cmpl_idle_regs #(
  parameter int LOCK_W = 2
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           cfg_we,
  input  logic [2:0]                     cfg_wdata,
  input  logic                           lock_we,
  input  logic [LOCK_W-1:0]              lock_wdata,
  output cmpl_idle_out_pkg::idle_t       idle_q,
  output logic [LOCK_W-1:0]              lock_q
);
  logic unlocked;
  assign unlocked = (lock_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      idle_q <= '0;
      lock_q <= '0;
    end else begin
      if (cfg_we && unlocked)
        idle_q <= cmpl_idle_out_pkg::idle_t'(cfg_wdata);
      if (lock_we && unlocked)
        lock_q <= lock_wdata;
    end
  end
endmodule

// File: rtl/cmpl_idle_pair.sv
module cmpl_idle_pair #(
  parameter int DT_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            moe,
  input  logic            ref_in,
  input  logic            idle_pos,
  input  logic            idle_neg,
  input  logic [DT_W-1:0] dt,
  output logic            out_pos,
  output logic            out_neg
);
  // target pair: {neg, pos}
  logic [1:0]      tgt, tgt_q, out_q;
  logic            moe_q, trig;
  logic [DT_W-1:0] cnt;

  assign tgt  = moe ? {~ref_in, ref_in} : {idle_neg, idle_pos};
  assign trig = (tgt != tgt_q) || (moe != moe_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q <= 2'b00;
      moe_q <= 1'b0;
      cnt   <= '0;
      out_q <= 2'b00;
    end else begin
      tgt_q <= tgt;
      moe_q <= moe;
      if (trig) begin
        if (dt == '0) begin
          cnt   <= '0;
          out_q <= tgt;
        end else begin
          cnt   <= dt;
          out_q <= 2'b00;
        end
      end else if (cnt > DT_W'(1)) begin
        cnt   <= cnt - DT_W'(1);
        out_q <= 2'b00;
      end else begin
        cnt   <= '0;
        out_q <= tgt;
      end
    end
  end

  assign out_pos = out_q[0];
  assign out_neg = out_q[1];
endmodule

// File: rtl/cmpl_idle_se.sv
module cmpl_idle_se (
  input  logic clk,
  input  logic rst,
  input  logic moe,
  input  logic ref_in,
  input  logic idle_lvl,
  output logic out
);
  always_ff @(posedge clk) begin
    if (rst) out <= 1'b0;
    else     out <= moe ? ref_in : idle_lvl;
  end
endmodule

// File: rtl/cmpl_idle_out.sv
module cmpl_idle_out #(
  parameter int DT_W   = 8,
  parameter int LOCK_W = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref1_i,
  input  logic              ref2_i,
  input  logic              moe_i,
  input  logic [DT_W-1:0]   dt_i,
  input  logic              cfg_we_i,
  input  logic [2:0]        cfg_wdata_i,
  input  logic              lock_we_i,
  input  logic [LOCK_W-1:0] lock_wdata_i,
  output logic              ch1_o,
  output logic              ch1n_o,
  output logic              ch2_o
);
  cmpl_idle_out_pkg::idle_t idle_q;
  logic [LOCK_W-1:0]        lock_q;

  cmpl_idle_regs #(.LOCK_W(LOCK_W)) u_regs (
    .clk(clk), .rst(rst),
    .cfg_we(cfg_we_i), .cfg_wdata(cfg_wdata_i),
    .lock_we(lock_we_i), .lock_wdata(lock_wdata_i),
    .idle_q(idle_q), .lock_q(lock_q)
  );

  cmpl_idle_pair #(.DT_W(DT_W)) u_pair (
    .clk(clk), .rst(rst), .moe(moe_i), .ref_in(ref1_i),
    .idle_pos(idle_q.pos), .idle_neg(idle_q.neg), .dt(dt_i),
    .out_pos(ch1_o), .out_neg(ch1n_o)
  );

  cmpl_idle_se u_se (
    .clk(clk), .rst(rst), .moe(moe_i), .ref_in(ref2_i),
    .idle_lvl(idle_q.se), .out(ch2_o)
  );
endmodule

// File: rtl/cmpl_idle_out_chk.sv
module cmpl_idle_out_chk #(
  parameter int LOCK_W = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              moe_i,
  input logic              ref2_i,
  input logic              ch1_o,
  input logic              ch1n_o,
  input logic              ch2_o,
  input logic [2:0]        idle_q,
  input logic [LOCK_W-1:0] lock_q
);
  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (!ch1_o && !ch1n_o && !ch2_o && idle_q == 3'b000 && lock_q == '0));

  a_r2_se_follows_ref: assert property (@(posedge clk) disable iff (rst)
    moe_i |=> (ch2_o == $past(ref2_i)));

  a_r4_no_overlap: assert property (@(posedge clk) disable iff (rst)
    $past(moe_i) |-> !(ch1_o && ch1n_o));

  a_r5_se_idle: assert property (@(posedge clk) disable iff (rst)
    !moe_i |=> (ch2_o == $past(idle_q[2])));

  a_r10_idle_frozen: assert property (@(posedge clk) disable iff (rst)
    (lock_q != '0) |=> $stable(idle_q));

  a_r11_lock_sticky: assert property (@(posedge clk) disable iff (rst)
    (lock_q != '0) |=> $stable(lock_q));
endmodule

bind cmpl_idle_out cmpl_idle_out_chk #(.LOCK_W(LOCK_W)) u_chk (
  .clk(clk), .rst(rst), .moe_i(moe_i), .ref2_i(ref2_i),
  .ch1_o(ch1_o), .ch1n_o(ch1n_o), .ch2_o(ch2_o),
  .idle_q(idle_q), .lock_q(lock_q)
);

// File: tb/test_cmpl_idle_out.sv
module test_cmpl_idle_out;
  localparam int CLK_PERIOD = 10;
  localparam int DT_W       = 8;
  localparam int LOCK_W     = 2;

  logic clk = 1'b0;
  logic rst, ref1, ref2, moe, cfg_we, lock_we;
  logic [DT_W-1:0]   dt;
  logic [2:0]        cfg_wdata;
  logic [LOCK_W-1:0] lock_wdata;
  logic ch1, ch1n, ch2;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  cmpl_idle_out #(.DT_W(DT_W), .LOCK_W(LOCK_W)) i_cmpl_idle_out (
    .clk(clk), .rst(rst), .ref1_i(ref1), .ref2_i(ref2), .moe_i(moe),
    .dt_i(dt), .cfg_we_i(cfg_we), .cfg_wdata_i(cfg_wdata),
    .lock_we_i(lock_we), .lock_wdata_i(lock_wdata),
    .ch1_o(ch1), .ch1n_o(ch1n), .ch2_o(ch2)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string req, logic [2:0] exp);
    n_tests++;
    if ({ch2, ch1n, ch1} !== exp) begin
      n_fail++;
      $display("FAIL %s: pins {ch2,ch1n,ch1} act=%b exp=%b at %0t", req, {ch2, ch1n, ch1}, exp, $time);
    end
  endtask

  // Steps d+2 edges from a triggering edge; pair is 0/0 for samples 1..d, then tgt={neg,pos}
  task automatic window(string req, int d, logic [1:0] tgt, bit en, logic exp2);
    for (int i = 1; i <= d + 2; i++) begin
      step();
      chk(req, {exp2, (i <= d) ? 2'b00 : tgt});
      if (en) begin
        n_tests++;
        if (ch1 && ch1n) begin
          n_fail++;
          $display("FAIL R4: both pair pins high act=11 exp=not11 at %0t", $time);
        end
      end
    end
  endtask

  task automatic cfg_write(logic [2:0] v);
    cfg_we = 1'b1; cfg_wdata = v;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) step();
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1; ref1 = 0; ref2 = 0; moe = 0; dt = '0;
    cfg_we = 0; cfg_wdata = '0; lock_we = 0; lock_wdata = '0;
    @(negedge clk);
    do_reset();
    chk("R1", 3'b000);
    step();
    chk("R1", 3'b000);

    // R9: write idle code with enable low; the idle change passes a dead-time of 3
    dt = 8'd3;
    cfg_write(3'b101);
    window("R9", 3, 2'b01, 1'b0, 1'b1);

    for (int d = 0; d <= 5; d++) begin
      for (int v = 0; v < 8; v++) begin
        logic [2:0] vb;
        vb = 3'(v);
        dt = 8'(d);
        // R3: enable with ref low -> main 0, complementary 1
        moe = 1'b1; ref1 = 1'b0; ref2 = 1'b0;
        window("R3", d, 2'b10, 1'b1, 1'b0);
        cfg_write(vb);
        chk("R3", 3'b010);
        // R3/R2: ref rises -> main 1 after dead-time, single-ended follows at once
        ref1 = 1'b1; ref2 = 1'b1;
        window((d == 0) ? "R7" : "R3", d, 2'b01, 1'b1, 1'b1);
        // R6/R5: enable falls -> idle levels after dead-time
        moe = 1'b0;
        window((d == 0) ? "R7" : "R6", d, {vb[1], vb[0]}, 1'b0, vb[2]);
        if (d >= 2) begin
          // R8: re-enable during an idle countdown
          moe = 1'b1;
          step();
          chk("R8", 3'b100);
          moe = 1'b0;
          step();
          chk("R8", {vb[2], 2'b00});
          moe = 1'b1;
          window("R8", d, 2'b01, 1'b1, 1'b1);
          moe = 1'b0;
          window("R6", d, {vb[1], vb[0]}, 1'b0, vb[2]);
        end
      end
    end

    // Idle code is now 3'b111 with enable low; pins 111
    chk("R6", 3'b111);
    dt = 8'd2;
    lock_we = 1'b1; lock_wdata = 2'd2;
    step();
    lock_we = 1'b0;
    cfg_write(3'b000);
    repeat (5) step();
    chk("R10", 3'b111);
    // R11: writing lock 0 after locking is ignored, so writes stay blocked
    lock_we = 1'b1; lock_wdata = 2'd0;
    step();
    lock_we = 1'b0;
    cfg_write(3'b010);
    repeat (5) step();
    chk("R11", 3'b111);
    lock_we = 1'b1; lock_wdata = 2'd1;
    step();
    lock_we = 1'b0;
    cfg_write(3'b000);
    repeat (5) step();
    chk("R10", 3'b111);

    // R1: reset clears lock and idle bits
    do_reset();
    chk("R1", 3'b000);
    dt = 8'd0;
    cfg_write(3'b110);
    window("R9", 0, 2'b10, 1'b0, 1'b1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: act=running exp=finished");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule